// File: doc/BRIEF.md
# Comparator Output and Interrupt Controller

This block is the digital control logic that sits beside an analog voltage comparator. The analog stage produces two raw compare results. One is for the positive input measured against an external pin. The other is for the positive input measured against an internal reference voltage. A select bit picks which of the two drives the readable output. Each raw result is brought into the clock domain through a synchronizer chain before it is used.

The readable output is registered. It is 1 when the selected compare says the positive input is higher, and 0 otherwise. While the comparator is switched off, the output is held at 1. Any movement of the output sets a sticky change flag, and that includes the rise caused by switching the comparator off. The flag raises an interrupt request when interrupts are enabled.

Right after the comparator is switched on, the analog stage is not trusted for a fixed settling time. During that window a status output shows that the block is not ready, and output movements do not set the flag. Software clears the flag with a one-cycle write pulse.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: With the comparator on and settled, `cmp_out` is 1 when the selected raw compare input is 1 and 0 when it is 0. A change on a raw input shows on `cmp_out` at the third rising clock edge after it is applied (two synchronizer stages, then the output register).
- R2: `ref_sel` = 1 selects `gt_ref` (internal reference) and `ref_sel` = 0 selects `gt_pin` (external pin). A change of `ref_sel` alone shows on `cmp_out` at the next rising edge.
- R3: While `cmp_en` is 0, `cmp_out` is 1 from the next rising edge on. Raw input and `ref_sel` activity then leaves both `cmp_out` and `chg_flag` unchanged.
- R4: When `cmp_out` changes value at a rising edge and `settling` was low in the cycle before that edge, `chg_flag` is 1 after that same edge.
- R5: Turning the comparator off while `cmp_out` is 0 makes `cmp_out` rise and sets `chg_flag`.
- R6: `settling` is high for exactly SETTLE_CYCLES cycles, starting with the first cycle in which `cmp_en` is 1. SETTLE_CYCLES is CLK_MHZ*SETTLE_NS/1000, rounded up, and at least 1. No output change during those cycles sets `chg_flag`. `settling` is low whenever `cmp_en` is 0. Turning off during the window and turning on again restarts the full window.
- R7: `chg_flag` stays 1 until a cycle with `flag_clr` = 1, and is 0 after that edge if no new flag-setting change occurs in that cycle.
- R8: When `flag_clr` and a flag-setting output change fall in the same cycle, `chg_flag` is 1 afterwards.
- R9: `irq_req` after each rising edge equals `chg_flag` AND `irq_en` as they were before that edge.
- R10: During and just after reset, with `cmp_en` low, `cmp_out` is 1, `chg_flag` is 0, `irq_req` is 0 and `settling` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gt_pin | input | 1 | Raw compare result, positive input above external pin |
| gt_ref | input | 1 | Raw compare result, positive input above internal reference |
| ref_sel | input | 1 | 1 selects the internal reference, 0 the external pin |
| cmp_en | input | 1 | Comparator on |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the change flag |
| cmp_out | output | 1 | Readable comparator output |
| chg_flag | output | 1 | Sticky output-change flag |
| irq_req | output | 1 | Registered interrupt request |
| settling | output | 1 | High while the post-enable settling window runs |

## Verification
Several kinds of input are applied to the main function, and each one tells a different fault apart.

- Slow steps on the pin input show whether the output has the right polarity and sits behind exactly two synchronizer stages.
- A one-cycle pulse on the raw input shows whether it passes through intact rather than being filtered or stretched.
- Driving the pin and reference inputs to opposite values, then flipping only the select bit, shows which source is really routed to the output. It also shows that the select bit bypasses the synchronizer delay.
- Switching the comparator off from a low output, re-enabling it in the middle of the window, and toggling the raw input inside the window shows the forced-high path apart from the settling mask.
- A clear pulse placed in exactly the cycle of a new change shows whether set wins over clear.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  // Settling window in clock cycles, rounded up, never below one.
  function automatic int unsigned settle_cycles(int unsigned clk_mhz, int unsigned settle_ns);
    int unsigned c;
    c = (clk_mhz * settle_ns + 999) / 1000;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Value the output register takes: forced high while off, else the selected compare.
  function automatic logic out_value(logic en, logic use_ref, logic pin_v, logic ref_v);
    if (!en) return 1'b1;
    return use_ref ? ref_v : pin_v;
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_settle.sv
module cmp_settle #(
  parameter int unsigned CYCLES = 1000,
  parameter int unsigned CW     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic settling
);
  logic          en_q;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      left <= '0;
    end else begin
      en_q <= en;
      if (!en)             left <= '0;
      else if (!en_q)      left <= CW'(CYCLES - 1);
      else if (left != '0) left <= left - 1'b1;
    end
  end

  // First enabled cycle counts as window cycle one.
  assign settling = en && (!en_q || (left != '0));
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= set_evt | (flag & ~clr);
      irq  <= flag & irq_en;
    end
  end
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl #(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned SETTLE_NS   = 10000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gt_pin,
  input  logic gt_ref,
  input  logic ref_sel,
  input  logic cmp_en,
  input  logic irq_en,
  input  logic flag_clr,
  output logic cmp_out,
  output logic chg_flag,
  output logic irq_req,
  output logic settling
);
  import cmp_irq_pkg::*;

  localparam int unsigned SETTLE_CYCLES = settle_cycles(CLK_MHZ, SETTLE_NS);
  localparam int unsigned CNT_W         = $clog2(SETTLE_CYCLES + 1);
  localparam int unsigned N_SRC         = 2;

  logic [N_SRC-1:0] raw_in;
  logic [N_SRC-1:0] raw_sync;
  logic             out_next;
  logic             out_change;
  logic             flag_set;

  assign raw_in = {gt_ref, gt_pin};

  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in[g]),
      .q    (raw_sync[g])
    );
  end

  cmp_settle #(.CYCLES(SETTLE_CYCLES), .CW(CNT_W)) i_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cmp_en),
    .settling(settling)
  );

  assign out_next   = out_value(cmp_en, ref_sel, raw_sync[0], raw_sync[1]);
  assign out_change = (out_next != cmp_out);
  assign flag_set   = out_change && !settling;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_out <= 1'b1;
    else        cmp_out <= out_next;
  end

  cmp_flag i_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(flag_set),
    .clr    (flag_clr),
    .irq_en (irq_en),
    .flag   (chg_flag),
    .irq    (irq_req)
  );
endmodule

// File: rtl/cmp_irq_chk.sv
module cmp_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmp_en,
  input logic flag_clr,
  input logic irq_en,
  input logic cmp_out,
  input logic chg_flag,
  input logic irq_req,
  input logic settling,
  input logic out_change,
  input logic flag_set
);
  assert_off_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> cmp_out);

  assert_change_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_change && !settling) |=> chg_flag);

  assert_window_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && !flag_clr) |=> $stable(chg_flag));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !flag_clr) |=> chg_flag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !chg_flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && flag_set) |=> chg_flag);

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && irq_en) |=> irq_req);

  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(chg_flag && irq_en));
endmodule

bind cmp_irq_ctrl cmp_irq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_en    (cmp_en),
  .flag_clr  (flag_clr),
  .irq_en    (irq_en),
  .cmp_out   (cmp_out),
  .chg_flag  (chg_flag),
  .irq_req   (irq_req),
  .settling  (settling),
  .out_change(out_change),
  .flag_set  (flag_set)
);

// File: tb/test_cmp_irq_ctrl.sv
module test_cmp_irq_ctrl;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gt_pin = 0, gt_ref = 0, ref_sel = 0, cmp_en = 0, irq_en = 0, flag_clr = 0;
  logic cmp_out, chg_flag, irq_req, settling;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string ph = "R10";

  always #5 clk = ~clk;

  cmp_irq_ctrl #(.CLK_MHZ(100), .SETTLE_NS(160), .SYNC_STAGES(2)) i_cmp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .gt_pin(gt_pin), .gt_ref(gt_ref), .ref_sel(ref_sel),
    .cmp_en(cmp_en), .irq_en(irq_en), .flag_clr(flag_clr),
    .cmp_out(cmp_out), .chg_flag(chg_flag), .irq_req(irq_req), .settling(settling)
  );

  typedef struct {
    logic  o;
    logic  f;
    logic  i;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference built from the requirements: history of sampled raw values,
  // length of the current enabled run, flag rules.
  logic [1:0] pin_h, ref_h;
  int   run_len;
  logic m_out, m_flag, m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_h = 2'b00; ref_h = 2'b00; run_len = 0;
      m_out = 1'b1; m_flag = 1'b0; m_irq = 1'b0;
      sb.delete();
    end else begin
      logic in_win;
      logic nout;
      exp_t it;
      in_win = cmp_en && (run_len + 1 <= WIN);
      nout   = !cmp_en ? 1'b1 : (ref_sel ? ref_h[1] : pin_h[1]);
      m_irq  = m_flag & irq_en;
      if ((nout != m_out) && !in_win) m_flag = 1'b1;
      else if (flag_clr)              m_flag = 1'b0;
      m_out   = nout;
      run_len = cmp_en ? run_len + 1 : 0;
      pin_h   = {pin_h[0], gt_pin};
      ref_h   = {ref_h[0], gt_ref};
      it.o = m_out; it.f = m_flag; it.i = m_irq; it.tag = ph;
      sb.push_back(it);
    end
  end

  // Monitor: compare at the falling edge, after the driver has settled inputs.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "cmp_out", cmp_out, e.o);
      chk(e.tag, "chg_flag", chg_flag, e.f);
      chk(e.tag, "irq_req (R9)", irq_req, e.i);
      chk(e.tag, "settling (R6)", settling, cmp_en && (run_len + 1 <= WIN));
    end
  end

  task automatic go(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clr_pulse();
    flag_clr = 1; go(1); flag_clr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state held in reset
    chk("R10", "cmp_out in reset", cmp_out, 1'b1);
    chk("R10", "chg_flag in reset", chg_flag, 1'b0);
    chk("R10", "irq_req in reset", irq_req, 1'b0);
    chk("R10", "settling in reset", settling, 1'b0);
    @(posedge clk); #2;
    rst_n = 1;
    go(4);

    ph = "R6";  cmp_en = 1; go(24);
    ph = "R7";  clr_pulse(); go(3);

    ph = "R1";  gt_pin = 1; go(6); gt_pin = 0; go(6);
    gt_pin = 1; go(1); gt_pin = 0; go(6);

    ph = "R7";  go(5); clr_pulse(); go(3);

    ph = "R9";  irq_en = 1; gt_pin = 1; go(6); clr_pulse(); go(3);
    irq_en = 0; gt_pin = 0; go(6); irq_en = 1; go(3); clr_pulse(); go(3);

    ph = "R2";  gt_ref = 1; go(4); ref_sel = 1; go(3); gt_ref = 0; go(5);
    ref_sel = 0; gt_pin = 1; go(5);

    ph = "R8";  clr_pulse(); go(2); gt_pin = 0; go(2); clr_pulse(); go(4);

    ph = "R5";  clr_pulse(); irq_en = 1; go(2); cmp_en = 0; go(4);

    ph = "R3";  clr_pulse(); gt_pin = 1; go(4); gt_pin = 0; go(4);
    ref_sel = 1; gt_ref = 0; go(3); ref_sel = 0; go(3);

    ph = "R4";  cmp_en = 1; go(20); gt_pin = 1; go(5); gt_pin = 0; go(5);

    ph = "R6";  cmp_en = 0; go(3); clr_pulse(); cmp_en = 1; go(5); cmp_en = 0; go(2);
    cmp_en = 1; go(4); gt_pin = 1; go(3); gt_pin = 0; go(20); clr_pulse(); go(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule